// File: doc/BRIEF.md
# Decimating Six-Channel Column Sequencer

This block takes 12-bit pixel codes from one shared input bus and spreads them over six channel registers, one code per active clock edge. A second register rank then presents all six codes at once on the channel outputs, which feed six column converters. The analog converters and their reference scaling are outside the block; only loading, transfer, polarity flag and power-down clearing are modelled.

The active edge is selectable, so two instances on the same bus and clock can take alternate words: one loads on rising edges and the other on falling edges. The fill order can run from channel 0 upward or from channel 5 downward, which mirrors the image. A load sequence is armed by a start pulse one active edge ahead of the first word. A transfer request sampled on a rising edge copies the first rank into the output rank on the falling edge that follows. Standby wipes all stored state.

Top module: `colseq_top`

## Requirements
- R1: With edge select high, if start is sampled high on rising edge k, the words present at rising edges k+1 to k+6 are stored in consecutive channel registers (channel i occupies bits 12i+11..12i of the code output, bit 11 of each word is the MSB).
- R2: With edge select low, the same sequence runs on falling edges, and rising edges store nothing.
- R3: With fill-down low the sequence writes channel 0 first and channel 5 last. With fill-down high it writes channel 5 first and channel 0 last.
- R4: The word on the bus at the edge where start is sampled is not stored by that start. Storing begins one active edge later.
- R5: After the sixth word of a sequence, further active edges store nothing until a new start is recognised.
- R6: A start recognised while a sequence is in progress restarts the fill at the first channel of the current direction.
- R7: Transfer sampled high on a rising edge copies all six first-rank registers into the output rank on the next falling edge. Without a transfer the code outputs hold.
- R8: A transfer issued during a sequence copies the words stored so far, including one stored on the same rising edge that samples the transfer.
- R9: While standby is high, both register ranks, the sequencer state and the strobes are zero. After standby falls, loading and transfer work again.
- R10: The invert flag output takes the invert input on each rising edge.
- R11: The load strobe is one-hot, with bit i set in the interval before the active edge that stores a word into channel i. It is zero when no word will be stored.
- R12: After reset, the codes, the invert flag and the strobes are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Pixel clock; both edges are used |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_data_i | input | 12 | Shared pixel code bus |
| seq_start_i | input | 1 | Arms a new load sequence |
| xfer_i | input | 1 | Requests copy of first rank to outputs |
| edge_rise_sel_i | input | 1 | 1: load on rising edges, 0: on falling edges |
| fill_down_i | input | 1 | 1: fill from channel 5 downward |
| invert_i | input | 1 | Polarity select for the output region |
| standby_i | input | 1 | Clears all stored state while high |
| chan_code_o | output | 72 | Six held codes, channel i at bits 12i+11..12i |
| invert_o | output | 1 | Registered polarity flag |
| load_strobe_o | output | 6 | One-hot strobe of the channel about to be written |

## Verification
On every cycle, the assertions check the following: the strobe stays one-hot or empty, an armed start opens a sequence at its first slot, a sixth word closes the sequence, and the first rank stays frozen on edges with no write. They also check that the output rank changes only on a falling edge after a sampled transfer and then equals the first rank, and that standby leaves the outputs at zero. The directed scenarios are what show the actual slot order in each edge mode and direction, that the word present with the start pulse is dropped, and that a restart in mid-sequence overwrites from the first channel. They also show the partial copy made by a transfer during loading and the recovery after standby.

// File: rtl/colseq_pkg.sv
`timescale 1ns/1ps
package colseq_pkg;

    // Channel slot for the pos-th word of a sequence in the given direction.
    function automatic int unsigned slot_of(int unsigned pos, logic down, int unsigned n);
        return down ? (n - 1 - pos) : pos;
    endfunction

endpackage

// File: rtl/colseq_loader.sv
`timescale 1ns/1ps
module colseq_loader
    import colseq_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int CH_N   = 6
) (
    input  logic                     clk_i,
    input  logic                     clr_ni,
    input  logic                     en_i,
    input  logic                     start_i,
    input  logic                     down_i,
    input  logic [DATA_W-1:0]        data_i,
    output logic [CH_N*DATA_W-1:0]   bank_o,
    output logic [CH_N-1:0]          strobe_o
);
    localparam int IDX_W  = (CH_N > 1) ? $clog2(CH_N) : 1;
    localparam int BANK_W = CH_N * DATA_W;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(CH_N - 1);

    typedef struct packed {
        logic              armed;
        logic              busy;
        logic [IDX_W-1:0]  cnt;
        logic [BANK_W-1:0] bank;
    } ld_state_t;

    ld_state_t        st_d, st_q;
    logic             wr;
    logic [IDX_W-1:0] pos;
    logic [IDX_W-1:0] slot;

    always_comb begin
        st_d     = st_q;
        strobe_o = '0;
        pos      = st_q.armed ? '0 : st_q.cnt;
        slot     = IDX_W'(slot_of(32'(pos), down_i, CH_N));
        wr       = en_i && (st_q.armed || st_q.busy);
        if (en_i) begin
            st_d.armed = start_i;
            if (wr) begin
                st_d.bank[int'(slot)*DATA_W +: DATA_W] = data_i;
                strobe_o[slot] = 1'b1;
                if (pos == LAST) begin
                    st_d.busy = 1'b0;
                    st_d.cnt  = '0;
                end else begin
                    st_d.busy = 1'b1;
                    st_d.cnt  = pos + IDX_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge clr_ni) begin
        if (!clr_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign bank_o = st_q.bank;

    // R4: an armed start opens the sequence at its first slot on that edge
    assert_first_word_opens_seq_R4: assert property (@(posedge clk_i) disable iff (!clr_ni)
        (en_i && st_q.armed) |=> (st_q.busy && st_q.cnt == IDX_W'(1)));

    // R6: a start arriving mid-sequence resets the pointer
    assert_restart_resets_ptr_R6: assert property (@(posedge clk_i) disable iff (!clr_ni)
        (en_i && st_q.armed && st_q.busy) |=> (st_q.cnt == IDX_W'(1)));

    // R5: the sixth word closes the sequence
    assert_seq_closes_R5: assert property (@(posedge clk_i) disable iff (!clr_ni)
        (en_i && st_q.busy && !st_q.armed && st_q.cnt == LAST) |=> !st_q.busy);

    // R5: edges without a write leave the first rank untouched
    assert_idle_bank_frozen_R5: assert property (@(posedge clk_i) disable iff (!clr_ni)
        !(en_i && (st_q.armed || st_q.busy)) |=> $stable(st_q.bank));

endmodule

// File: rtl/colseq_xfer.sv
`timescale 1ns/1ps
module colseq_xfer #(
    parameter int DATA_W = 12,
    parameter int CH_N   = 6
) (
    input  logic                    clk_i,
    input  logic                    clr_ni,
    input  logic                    xfer_i,
    input  logic                    invert_i,
    input  logic [CH_N*DATA_W-1:0]  bank_i,
    output logic [CH_N*DATA_W-1:0]  code_o,
    output logic                    invert_o
);
    localparam int BANK_W = CH_N * DATA_W;

    typedef struct packed {
        logic pend;
        logic inv;
    } ctl_t;

    ctl_t              ctl_d, ctl_q;
    logic [BANK_W-1:0] out_d, out_q;

    always_comb begin
        ctl_d.pend = xfer_i;
        ctl_d.inv  = invert_i;
        out_d      = ctl_q.pend ? bank_i : out_q;
    end

    always_ff @(posedge clk_i or negedge clr_ni) begin
        if (!clr_ni) ctl_q <= '0;
        else         ctl_q <= ctl_d;
    end

    always_ff @(negedge clk_i or negedge clr_ni) begin
        if (!clr_ni) out_q <= '0;
        else         out_q <= out_d;
    end

    assign code_o   = out_q;
    assign invert_o = ctl_q.inv;

    // R7: without a pending transfer the output rank holds
    assert_outputs_hold_R7: assert property (@(negedge clk_i) disable iff (!clr_ni)
        !ctl_q.pend |=> $stable(out_q));

    // R7: a pending transfer copies the first rank as it stood before the edge
    assert_xfer_copies_rank_R7: assert property (@(negedge clk_i) disable iff (!clr_ni)
        ctl_q.pend |=> (out_q == $past(bank_i)));

endmodule

// File: rtl/colseq_top.sv
`timescale 1ns/1ps
module colseq_top #(
    parameter int DATA_W = 12,
    parameter int CH_N   = 6
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic [DATA_W-1:0]       pix_data_i,
    input  logic                    seq_start_i,
    input  logic                    xfer_i,
    input  logic                    edge_rise_sel_i,
    input  logic                    fill_down_i,
    input  logic                    invert_i,
    input  logic                    standby_i,
    output logic [CH_N*DATA_W-1:0]  chan_code_o,
    output logic                    invert_o,
    output logic [CH_N-1:0]         load_strobe_o
);
    localparam int BANK_W = CH_N * DATA_W;
    localparam int EDGES  = 2;

    logic              clr_n;
    logic [BANK_W-1:0] bank_w [EDGES];
    logic [CH_N-1:0]   strb_w [EDGES];
    logic [BANK_W-1:0] first_rank;

    assign clr_n = rst_ni & ~standby_i;

    // g = 0 loads on rising edges, g = 1 on falling edges
    for (genvar g = 0; g < EDGES; g++) begin : g_edge
        logic lclk;
        logic len;
        assign lclk = (g == 0) ? clk_i : ~clk_i;
        assign len  = (g == 0) ? edge_rise_sel_i : ~edge_rise_sel_i;

        colseq_loader #(.DATA_W(DATA_W), .CH_N(CH_N)) i_loader (
            .clk_i    (lclk),
            .clr_ni   (clr_n),
            .en_i     (len),
            .start_i  (seq_start_i),
            .down_i   (fill_down_i),
            .data_i   (pix_data_i),
            .bank_o   (bank_w[g]),
            .strobe_o (strb_w[g])
        );
    end

    assign first_rank    = edge_rise_sel_i ? bank_w[0] : bank_w[1];
    assign load_strobe_o = edge_rise_sel_i ? strb_w[0] : strb_w[1];

    colseq_xfer #(.DATA_W(DATA_W), .CH_N(CH_N)) i_xfer (
        .clk_i    (clk_i),
        .clr_ni   (clr_n),
        .xfer_i   (xfer_i),
        .invert_i (invert_i),
        .bank_i   (first_rank),
        .code_o   (chan_code_o),
        .invert_o (invert_o)
    );

    // R9: standby keeps every held code and strobe at zero
    assert_standby_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        standby_i |-> (chan_code_o == '0 && load_strobe_o == '0 && !invert_o));

    // R11: at most one channel is strobed
    assert_strobe_onehot_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(load_strobe_o));

endmodule

// File: tb/test_colseq_top.sv
`timescale 1ns/1ps
module test_colseq_top;
    localparam int DW = 12;
    localparam int CN = 6;
    localparam int BW = DW * CN;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [DW-1:0] pix = '0;
    logic          start = 1'b0, xfer = 1'b0, rise_sel = 1'b1, down = 1'b0;
    logic          inv = 1'b0, stby = 1'b0;
    logic [BW-1:0] codes;
    logic          inv_o;
    logic [CN-1:0] strobe;

    int n_chk = 0;
    int n_bad = 0;
    logic [BW-1:0] exp_codes;
    logic [BW-1:0] prev_codes;

    always #2 clk = ~clk;

    colseq_top #(.DATA_W(DW), .CH_N(CN)) i_colseq_top (
        .clk_i(clk), .rst_ni(rst_n), .pix_data_i(pix), .seq_start_i(start),
        .xfer_i(xfer), .edge_rise_sel_i(rise_sel), .fill_down_i(down),
        .invert_i(inv), .standby_i(stby), .chan_code_o(codes),
        .invert_o(inv_o), .load_strobe_o(strobe)
    );

    task automatic chk(string tag, logic [BW-1:0] got, logic [BW-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    function automatic int slot(int i, logic dn);
        return dn ? (CN - 1 - i) : i;
    endfunction

    task automatic step();
        if (rise_sel) @(posedge clk); else @(negedge clk);
        #1;
    endtask

    task automatic do_xfer();
        @(negedge clk); #1 xfer = 1'b1;
        @(posedge clk); #1 xfer = 1'b0;
        @(negedge clk); #1;
    endtask

    task automatic clear_all();
        stby = 1'b1; #4 stby = 1'b0; #2;
    endtask

    // Full sequence of six words base+i; checks strobes (R11) and builds exp_codes
    task automatic load_seq(logic rs, logic dn, logic [DW-1:0] base);
        rise_sel = rs; down = dn;
        step();
        start = 1'b1; pix = 12'hBAD;
        step();
        start = 1'b0;
        exp_codes = '0;
        for (int i = 0; i < CN; i++) begin
            pix = base + DW'(i);
            chk("R11 strobe", BW'(strobe), BW'(6'(1) << slot(i, dn)));
            exp_codes[slot(i, dn)*DW +: DW] = base + DW'(i);
            step();
        end
        chk("R5 strobe idle", BW'(strobe), '0);
    endtask

    task automatic t_reset();
        chk("R12 codes", codes, '0);
        chk("R12 invert", BW'(inv_o), '0);
        chk("R12 strobe", BW'(strobe), '0);
    endtask

    task automatic t_rise_up();
        load_seq(1'b1, 1'b0, 12'h100);
        do_xfer();
        chk("R1 rising fill up", codes, exp_codes);
    endtask

    task automatic t_rise_down_hold();
        prev_codes = codes;
        load_seq(1'b1, 1'b1, 12'h200);
        repeat (3) @(negedge clk);
        #1 chk("R7 hold without transfer", codes, prev_codes);
        do_xfer();
        chk("R3 rising fill down", codes, exp_codes);
    endtask

    task automatic t_fall_up();
        load_seq(1'b0, 1'b0, 12'h300);
        do_xfer();
        chk("R2 falling fill up", codes, exp_codes);
    endtask

    task automatic t_fall_down();
        load_seq(1'b0, 1'b1, 12'hC40);
        do_xfer();
        chk("R2 R3 falling fill down", codes, exp_codes);
    endtask

    task automatic t_extra_edges();
        load_seq(1'b1, 1'b0, 12'h510);
        pix = 12'hFFF;
        repeat (4) begin
            chk("R5 strobe after sixth", BW'(strobe), '0);
            step();
        end
        do_xfer();
        chk("R5 extra edges ignored", codes, exp_codes);
    endtask

    // start sampled with 0xABC on the bus, 0x111 next edge, 0x222 on the transfer edge
    task automatic t_arm_ahead_midxfer();
        clear_all();
        rise_sel = 1'b1; down = 1'b0;
        step();
        start = 1'b1; pix = 12'hABC;
        step();
        start = 1'b0; pix = 12'h111;
        step();
        pix = 12'h222;
        do_xfer();
        exp_codes = '0;
        exp_codes[0*DW +: DW] = 12'h111;
        exp_codes[1*DW +: DW] = 12'h222;
        chk("R4 R8 partial copy mid-load", codes, exp_codes);
        repeat (6) step();
        clear_all();
    endtask

    task automatic t_restart();
        rise_sel = 1'b1; down = 1'b0;
        step();
        start = 1'b1; pix = 12'h000;
        step();
        start = 1'b0;
        pix = 12'hA00; step();
        pix = 12'hA01; step();
        pix = 12'hA02; start = 1'b1; step();
        start = 1'b0;
        exp_codes = '0;
        for (int i = 0; i < CN; i++) begin
            pix = 12'hB00 + DW'(i);
            exp_codes[i*DW +: DW] = 12'hB00 + DW'(i);
            if (i == 0) chk("R6 strobe back to ch0", BW'(strobe), BW'(1));
            step();
        end
        do_xfer();
        chk("R6 restart overwrites from first", codes, exp_codes);
    endtask

    task automatic t_standby();
        load_seq(1'b1, 1'b1, 12'h700);
        do_xfer();
        chk("R9 loaded before standby", codes, exp_codes);
        start = 1'b1;
        stby = 1'b1;
        #1 chk("R9 codes cleared", codes, '0);
        chk("R9 strobe cleared", BW'(strobe), '0);
        #4 start = 1'b0;
        #4 stby = 1'b0;
        #2;
        pix = 12'h0EE;
        step(); step();
        do_xfer();
        chk("R9 rank and arm cleared", codes, '0);
        load_seq(1'b1, 1'b0, 12'h820);
        do_xfer();
        chk("R9 resumes after standby", codes, exp_codes);
    endtask

    task automatic t_invert();
        @(negedge clk); #1 inv = 1'b1;
        #0.5 chk("R10 invert before edge", BW'(inv_o), '0);
        @(posedge clk); #1 chk("R10 invert set", BW'(inv_o), BW'(1));
        @(negedge clk); #1 inv = 1'b0;
        @(posedge clk); #1 chk("R10 invert clear", BW'(inv_o), '0);
    endtask

    logic done = 1'b0;

    initial begin
        #200000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #5 rst_n = 1'b1;
        #2;
        t_reset();
        t_rise_up();
        t_rise_down_hold();
        t_fall_up();
        t_fall_down();
        t_extra_edges();
        t_arm_ahead_midxfer();
        t_restart();
        t_standby();
        t_invert();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule